// File: doc/BRIEF.md
# Sixteen-Register Hex-Opcode CPU Core

This block is a small multicycle processor for a 16-bit, hex-digit instruction set. It has sixteen 8-bit general registers, an 8-bit program counter, and a 16-bit instruction register. It runs a repeating fetch, decode and execute loop against a 256-byte memory that is addressed by byte. Each instruction is made of two consecutive bytes, with the high byte at the lower address. The top hex digit of an instruction is the opcode. The other three digits are register selectors or an 8-bit address or immediate, and how they are read depends on the opcode.

The core supports:
- loads from memory and immediate loads;
- stores;
- register-to-register copy;
- wrapping add, OR, AND and XOR;
- a circular right rotate that takes one step per clock;
- a jump taken when a chosen register equals register 0;
- halt.

Any other opcode, including the floating-point add, acts as a no-op. The memory port is synchronous: an address that carries a read strobe returns its byte on `mem_rdata` in the next cycle. The program counter and the whole register file are brought out as debug outputs so that an environment can watch progress.

Top module: `hexcpu_core`

## Requirements
- R1: While `rst_n` is low and right after reset, `dbg_pc` is 0x00, every register in `dbg_regs` is 0x00 (register i sits at bits [8i+7:8i]), and `halted` is 0.
- R2: Fetch reads the byte at PC into instruction bits [15:8] and the byte at PC+1 into bits [7:0]. PC then advances by 2 before execute, so after a halt at address A, `dbg_pc` reads A+2.
- R3: Opcode 0x2 with fields R=[11:8] and XY=[7:0] writes XY into register R. Opcode 0x4 copies register [7:4] into register [3:0].
- R4: Opcode 0x1 loads register [11:8] from memory byte [7:0]. Opcode 0x3 writes register [11:8] to memory byte [7:0] with one `mem_we` strobe. Reads and writes are never strobed in the same cycle.
- R5: Opcode 0x5 writes (reg[7:4] + reg[3:0]) mod 256 into register [11:8].
- R6: Opcodes 0x7, 0x8 and 0x9 write the bitwise OR, AND and XOR, in that order, of registers [7:4] and [3:0] into register [11:8].
- R7: Opcode 0xA rotates register [11:8] right by one bit per clock, [3:0] times. The low bit re-enters at the top. A count of 0 leaves the register unchanged, and a count of 8 or more wraps, so 11 acts like 3.
- R8: Opcode 0xB loads PC with [7:0] when register [11:8] equals register 0. Otherwise execution continues in sequence.
- R9: Opcode 0xC halts the core. From then on `halted` stays 1, `dbg_pc` is stable, and neither `mem_re` nor `mem_we` is asserted until reset.
- R10: Opcodes 0x0, 0x6, 0xD, 0xE and 0xF change no register and write no memory. They only advance PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory byte address |
| mem_re | output | 1 | Read strobe; data returns on mem_rdata next cycle |
| mem_we | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read data from the previous cycle's read |
| halted | output | 1 | Core has executed a halt |
| dbg_pc | output | 8 | Program counter |
| dbg_regs | output | 128 | Register file, register i at bits [8i+7:8i] |

## Verification
A fault in the instruction register or in field decoding shows up at the ports within one instruction, about four clocks. It appears as a store to the wrong address or with the wrong data, or as a store that is missing or should not have happened. Test programs therefore write each computed register to its own address, and a scoreboard compares the store stream in order. A wrong PC after a jump or a halt shows up as a skipped or extra store and as a wrong final `dbg_pc`. A halt state that leaks shows up as memory strobes after `halted` rises.

// File: rtl/hexcpu_core.sv
module hexcpu_core (
  input  logic         clk,
  input  logic         rst_n,
  output logic [7:0]   mem_addr,
  output logic         mem_re,
  output logic         mem_we,
  output logic [7:0]   mem_wdata,
  input  logic [7:0]   mem_rdata,
  output logic         halted,
  output logic [7:0]   dbg_pc,
  output logic [127:0] dbg_regs
);
  localparam int DW   = 8;
  localparam int NREG = 16;
  localparam int IW   = 2 * DW;

  typedef enum logic [2:0] {S_F0, S_F1, S_F2, S_EX, S_LD, S_ROT, S_HLT} st_t;

  st_t           state;
  logic [DW-1:0] pc;
  logic [IW-1:0] ir;
  logic [3:0]    rcnt;
  logic [DW-1:0] rf [NREG];

  wire [3:0]    op = ir[15:12];
  wire [3:0]    fr = ir[11:8];
  wire [3:0]    fs = ir[7:4];
  wire [3:0]    ft = ir[3:0];
  wire [DW-1:0] xy = ir[7:0];

  assign mem_addr  = (state == S_F1) ? pc + 8'd1 : (state == S_EX) ? xy : pc;
  assign mem_re    = (state == S_F0) || (state == S_F1) || (state == S_EX && op == 4'h1);
  assign mem_we    = (state == S_EX) && (op == 4'h3);
  assign mem_wdata = rf[fr];
  assign halted    = (state == S_HLT);
  assign dbg_pc    = pc;

  for (genvar i = 0; i < NREG; i++) begin : g_dbg
    assign dbg_regs[i*DW +: DW] = rf[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_F0;
      pc    <= '0;
      ir    <= '0;
      rcnt  <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (state)
        S_F0: state <= S_F1;
        S_F1: begin
          ir[15:8] <= mem_rdata;
          state    <= S_F2;
        end
        S_F2: begin
          ir[7:0] <= mem_rdata;
          pc      <= pc + 8'd2;
          state   <= S_EX;
        end
        S_EX: begin
          state <= S_F0;
          case (op)
            4'h1: state <= S_LD;
            4'h2: rf[fr] <= xy;
            4'h4: rf[ft] <= rf[fs];
            4'h5: rf[fr] <= rf[fs] + rf[ft];
            4'h7: rf[fr] <= rf[fs] | rf[ft];
            4'h8: rf[fr] <= rf[fs] & rf[ft];
            4'h9: rf[fr] <= rf[fs] ^ rf[ft];
            4'hA: if (ft != 4'd0) begin
              rcnt  <= ft;
              state <= S_ROT;
            end
            4'hB: if (rf[fr] == rf[0]) pc <= xy;
            4'hC: state <= S_HLT;
            default: ;
          endcase
        end
        S_LD: begin
          rf[fr] <= mem_rdata;
          state  <= S_F0;
        end
        S_ROT: begin
          rf[fr] <= {rf[fr][0], rf[fr][DW-1:1]};
          rcnt   <= rcnt - 4'd1;
          if (rcnt == 4'd1) state <= S_F0;
        end
        default: state <= S_HLT;
      endcase
    end
  end

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_re && !mem_we));
  assert_halt_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(dbg_pc));
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_F2) |=> (pc == $past(pc) + 8'd2));
  assert_one_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  assert_rot_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ROT && rcnt != 4'd1) |=> (state == S_ROT && rcnt == $past(rcnt) - 4'd1));
endmodule

// File: tb/hexcpu_core_bench.sv
module hexcpu_core_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   mem_addr, mem_wdata, mem_rdata;
  logic         mem_re, mem_we, halted;
  logic [7:0]   dbg_pc;
  logic [127:0] dbg_regs;

  int nchk = 0;
  int nfail = 0;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] data;
    string      tag;
  } wr_t;
  wr_t exp_q[$];

  logic [7:0] mem [256];

  always #5 clk = ~clk;

  hexcpu_core u_hexcpu_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted),
    .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    wr_t e;
    e.addr = a;
    e.data = d;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] ins);
    mem[a]      = ins[15:8];
    mem[a+8'd1] = ins[7:0];
  endtask

  function automatic logic [7:0] reg_of(input int i);
    return dbg_regs[i*8 +: 8];
  endfunction

  // monitor: pop the scoreboard on every store
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8/R10 unexpected store", {mem_addr, mem_wdata}, 0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        chk(mem_addr == e.addr && mem_wdata == e.data, e.tag,
            {mem_addr, mem_wdata}, {e.addr, e.data});
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin : main
    int cyc;
    int busy;
    logic [7:0] pc_h;
    bit allz;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h90] = 8'h5A;
    put(8'h00, 16'h2005); put(8'h02, 16'h2103); put(8'h04, 16'h5201);
    put(8'h06, 16'h3280); expect_wr(8'h80, 8'h08, "R5 add");
    put(8'h08, 16'h23F0); put(8'h0A, 16'h243C); put(8'h0C, 16'h7534);
    put(8'h0E, 16'h3581); expect_wr(8'h81, 8'hFC, "R6 or");
    put(8'h10, 16'h8634);
    put(8'h12, 16'h3682); expect_wr(8'h82, 8'h30, "R6 and");
    put(8'h14, 16'h9734);
    put(8'h16, 16'h3783); expect_wr(8'h83, 8'hCC, "R6 xor");
    put(8'h18, 16'h28FF); put(8'h1A, 16'h5981);
    put(8'h1C, 16'h3984); expect_wr(8'h84, 8'h02, "R5 add wrap");
    put(8'h1E, 16'h1A90);
    put(8'h20, 16'h3A85); expect_wr(8'h85, 8'h5A, "R4 load");
    put(8'h22, 16'h40AB);
    put(8'h24, 16'h3B86); expect_wr(8'h86, 8'h5A, "R3 copy");
    put(8'h26, 16'h2C96); put(8'h28, 16'hAC03);
    put(8'h2A, 16'h3C87); expect_wr(8'h87, 8'hD2, "R7 rotate 3");
    put(8'h2C, 16'h2D96); put(8'h2E, 16'hAD00);
    put(8'h30, 16'h3D88); expect_wr(8'h88, 8'h96, "R7 rotate 0");
    put(8'h32, 16'h2E96); put(8'h34, 16'hAE0B);
    put(8'h36, 16'h3E89); expect_wr(8'h89, 8'hD2, "R7 rotate 11");
    put(8'h38, 16'h6012); put(8'h3A, 16'h0FFF); put(8'h3C, 16'hD123);
    put(8'h3E, 16'h308A); expect_wr(8'h8A, 8'h05, "R10 no-ops");
    put(8'h40, 16'h2F05); put(8'h42, 16'hBF48);
    put(8'h44, 16'h3F8B); put(8'h46, 16'hC000);
    put(8'h48, 16'hB14E);
    put(8'h4A, 16'h318C); expect_wr(8'h8C, 8'h03, "R8 branch not taken");
    put(8'h4C, 16'hC000);
    put(8'h4E, 16'h3F8D);

    repeat (3) @(posedge clk);
    @(negedge clk);
    allz = (dbg_regs == '0);
    chk(dbg_pc == 8'h00 && !halted && allz, "R1 reset state", {dbg_pc, 7'd0, halted}, 0);
    rst_n = 1'b1;

    cyc = 0;
    while (!halted && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(halted, "R9 halt reached", halted, 1);
    chk(dbg_pc == 8'h4E, "R2 pc after halt", dbg_pc, 8'h4E);
    chk(exp_q.size() == 0, "R8 stores outstanding", exp_q.size(), 0);
    chk(reg_of(0) == 8'h05, "R10 reg0 kept", reg_of(0), 8'h05);
    chk(reg_of(2) == 8'h08, "R5 reg2", reg_of(2), 8'h08);
    chk(reg_of(11) == 8'h5A, "R3 reg11", reg_of(11), 8'h5A);
    chk(reg_of(12) == 8'hD2, "R7 reg12", reg_of(12), 8'hD2);
    chk(reg_of(6) == 8'h30, "R6 reg6", reg_of(6), 8'h30);
    chk(mem[8'h80] == 8'h08, "R4 memory written", mem[8'h80], 8'h08);
    chk(mem[8'h8B] == 8'h00, "R8 jump skipped store", mem[8'h8B], 8'h00);

    busy = 0;
    pc_h = dbg_pc;
    repeat (20) begin
      @(negedge clk);
      if (mem_re || mem_we || !halted || dbg_pc != pc_h) busy++;
    end
    chk(busy == 0, "R9 idle after halt", busy, 0);

    rst_n = 1'b0;
    @(negedge clk);
    allz = (dbg_regs == '0);
    chk(dbg_pc == 8'h00 && !halted && allz, "R1 second reset", {dbg_pc, 7'd0, halted}, 0);

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule